// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block holds in-flight instructions in a circular buffer, in the order they were issued. Instructions can finish in any order, but they retire strictly in issue order. On issue, an instruction takes the slot at the tail. The slot index comes back at once and serves as the result tag. Execution units later post results by tag on a result port. A lookup port hands a completed but not yet committed value to a newly issued consumer, so that consumer need not wait for the register file.

The oldest entry retires only when it is ready:

- A register operation drives a register-file write.
- A store drives a memory write.
- A correctly predicted branch retires silently.
- A mispredicted branch raises a redirect carrying the correct successor address. It also empties the whole buffer, so all younger speculative work is discarded.

When all slots are taken, issue stalls until a commit frees the head slot.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `iss_stall_o`=0, `iss_tag_o`=0, `lk_hit_o`=0, and no write or redirect output is active.
- R2: An issue is accepted when `iss_valid_i`=1 and `iss_stall_o`=0. The accepted instruction takes tag `iss_tag_o`. Tags run 0,1,2,… modulo DEPTH in issue order. At most one issue is accepted per cycle.
- R3: A result write (`res_valid_i`) to an allocated tag stores the value, mispredict flag and target, and marks the entry ready. From the next cycle, a lookup of that tag gives `lk_hit_o`=1 and the value. A write to an unallocated tag is ignored, and a freshly issued entry is never hit.
- R4: Only the oldest entry can retire, and only once it is ready. Younger ready entries wait, and commits follow issue order.
- R5: A ready register operation at the head (kind code 2) drives `reg_we_o`=1 in the same cycle, with `reg_idx_o` = the low REG_W bits of its destination and `reg_data_o` = its value. It retires at the next edge.
- R6: A ready store at the head (kind code 1) drives `mem_we_o`=1, with `mem_addr_o` = its destination and `mem_data_o` = its value. It drives no register write.
- R7: A ready branch at the head (kind code 0) with mispredict flag 0 retires with no register write, no memory write and no redirect.
- R8: A ready branch at the head with mispredict flag 1 drives `redirect_o`=1 and `redirect_pc_o` = its target. After the next edge the buffer is empty, `iss_tag_o`=0, and lookups of old tags miss.
- R9: With DEPTH entries occupied, `iss_stall_o`=1 unless the head commits in that cycle. When the buffer is full and the head commits, an issue is accepted in the same cycle.
- R10: In a cycle where `redirect_o`=1, `iss_stall_o`=1, and a result write in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| iss_valid_i | input | 1 | Issue request |
| iss_kind_i | input | 2 | Kind: 0 branch, 1 store, 2 register operation |
| iss_dest_i | input | DEST_W | Register number or store address |
| iss_stall_o | output | 1 | Issue cannot be accepted this cycle |
| iss_tag_o | output | TAG_W | Tag assigned to the issuing instruction |
| res_valid_i | input | 1 | Result write strobe |
| res_tag_i | input | TAG_W | Entry written |
| res_value_i | input | DATA_W | Result value |
| res_mispred_i | input | 1 | Branch was mispredicted |
| res_target_i | input | DATA_W | Correct branch successor |
| lk_tag_i | input | TAG_W | Operand lookup tag |
| lk_hit_o | output | 1 | Looked-up entry is allocated and ready |
| lk_value_o | output | DATA_W | Looked-up value |
| reg_we_o | output | 1 | Register-file write |
| reg_idx_o | output | REG_W | Register written |
| reg_data_o | output | DATA_W | Register data |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | DEST_W | Store address |
| mem_data_o | output | DATA_W | Store data |
| redirect_o | output | 1 | Mispredict restart |
| redirect_pc_o | output | DATA_W | Restart address |

## Verification
- **Issue tag:** it is combinational and is sampled in the cycle before the accepting edge.
- **Result writes:** a write lands at an edge. Its lookup hit, and a commit output it enables at the head, appear in the cycle after that edge. The entry retires at the following edge.
- **Redirect:** it appears in the cycle the mispredicted branch is at the head and ready. The emptied state (tag 0, misses) is checked one cycle later.

The bench drives inputs just after a rising edge and samples at the falling edge. A scoreboard queue, filled in issue order by the driver, is compared against each register write, memory write and redirect as it appears.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_BRANCH = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_REG    = 2'd2
  } kind_e;
endpackage

// File: rtl/rob_ptr.sv
// Circular pointer with wrap bit; supports any DEPTH >= 2.
module rob_ptr #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           adv_i,
  input  logic           clr_i,
  output logic [TAG_W:0] ptr_o
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
    end else if (clr_i) begin
      ptr_o <= '0;
    end else if (adv_i) begin
      if (ptr_o[TAG_W-1:0] == LAST) ptr_o <= {~ptr_o[TAG_W], {TAG_W{1'b0}}};
      else                          ptr_o <= ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  alloc_idx_i,
  input  kind_e             alloc_kind_i,
  input  logic [DEST_W-1:0] alloc_dest_i,
  input  logic              free_i,
  input  logic [TAG_W-1:0]  free_idx_i,
  input  logic              wr_i,
  input  logic [TAG_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_value_i,
  input  logic              wr_mis_i,
  input  logic [DATA_W-1:0] wr_tgt_i,
  input  logic [TAG_W-1:0]  head_idx_i,
  output kind_e             head_kind_o,
  output logic [DEST_W-1:0] head_dest_o,
  output logic [DATA_W-1:0] head_value_o,
  output logic              head_ready_o,
  output logic              head_mis_o,
  output logic [DATA_W-1:0] head_tgt_o,
  input  logic [TAG_W-1:0]  lk_idx_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_value_o
);
  logic              valid_q [DEPTH];
  logic              ready_q [DEPTH];
  kind_e             kind_q  [DEPTH];
  logic [DEST_W-1:0] dest_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];
  logic              mis_q   [DEPTH];
  logic [DATA_W-1:0] tgt_q   [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic alloc_here, free_here, wr_here;
    assign alloc_here = alloc_i && (alloc_idx_i == TAG_W'(i));
    assign free_here  = free_i  && (free_idx_i  == TAG_W'(i));
    assign wr_here    = wr_i    && (wr_idx_i    == TAG_W'(i)) && valid_q[i];

    // Alloc beats free: on a full-buffer issue+commit both hit the same slot.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        ready_q[i] <= 1'b0;
      end else if (clr_i) begin
        valid_q[i] <= 1'b0;
        ready_q[i] <= 1'b0;
      end else if (alloc_here) begin
        valid_q[i] <= 1'b1;
        ready_q[i] <= 1'b0;
      end else if (free_here) begin
        valid_q[i] <= 1'b0;
        ready_q[i] <= 1'b0;
      end else if (wr_here) begin
        ready_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (alloc_here) begin
        kind_q[i] <= alloc_kind_i;
        dest_q[i] <= alloc_dest_i;
      end
      if (wr_here && !clr_i) begin
        value_q[i] <= wr_value_i;
        mis_q[i]   <= wr_mis_i;
        tgt_q[i]   <= wr_tgt_i;
      end
    end
  end

  assign head_kind_o  = kind_q[head_idx_i];
  assign head_dest_o  = dest_q[head_idx_i];
  assign head_value_o = value_q[head_idx_i];
  assign head_ready_o = ready_q[head_idx_i];
  assign head_mis_o   = mis_q[head_idx_i];
  assign head_tgt_o   = tgt_q[head_idx_i];
  assign lk_hit_o     = valid_q[lk_idx_i] && ready_q[lk_idx_i];
  assign lk_value_o   = value_q[lk_idx_i];
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              empty_i,
  input  logic              ready_i,
  input  kind_e             kind_i,
  input  logic [DEST_W-1:0] dest_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic              mis_i,
  input  logic [DATA_W-1:0] tgt_i,
  output logic              commit_o,
  output logic              flush_o,
  output logic              reg_we_o,
  output logic [REG_W-1:0]  reg_idx_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              mem_we_o,
  output logic [DEST_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              redirect_o,
  output logic [DATA_W-1:0] redirect_pc_o
);
  always_comb begin
    commit_o   = !empty_i && ready_i;
    reg_we_o   = commit_o && (kind_i == KIND_REG);
    mem_we_o   = commit_o && (kind_i == KIND_STORE);
    redirect_o = commit_o && (kind_i == KIND_BRANCH) && mis_i;
    flush_o    = redirect_o;
  end

  assign reg_idx_o     = dest_i[REG_W-1:0];
  assign reg_data_o    = value_i;
  assign mem_addr_o    = dest_i;
  assign mem_data_o    = value_i;
  assign redirect_pc_o = tgt_i;
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 32,
  parameter int REG_W  = 5,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [1:0]        iss_kind_i,
  input  logic [DEST_W-1:0] iss_dest_i,
  output logic              iss_stall_o,
  output logic [TAG_W-1:0]  iss_tag_o,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_value_i,
  input  logic              res_mispred_i,
  input  logic [DATA_W-1:0] res_target_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_value_o,
  output logic              reg_we_o,
  output logic [REG_W-1:0]  reg_idx_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              mem_we_o,
  output logic [DEST_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              redirect_o,
  output logic [DATA_W-1:0] redirect_pc_o
);
  logic [TAG_W:0]    head_q, tail_q;
  logic              full, empty, commit, flush, iss_go;
  kind_e             h_kind;
  logic [DEST_W-1:0] h_dest;
  logic [DATA_W-1:0] h_value, h_tgt;
  logic              h_ready, h_mis;

  assign empty  = (head_q == tail_q);
  assign full   = (head_q[TAG_W] != tail_q[TAG_W]) &&
                  (head_q[TAG_W-1:0] == tail_q[TAG_W-1:0]);
  // Flush wins over issue; a committing head frees room in a full buffer.
  assign iss_stall_o = flush || (full && !commit);
  assign iss_go      = iss_valid_i && !iss_stall_o;
  assign iss_tag_o   = tail_q[TAG_W-1:0];

  rob_ptr #(.DEPTH(DEPTH)) u_tail (
    .clk_i, .rst_ni, .adv_i(iss_go), .clr_i(flush), .ptr_o(tail_q)
  );

  rob_ptr #(.DEPTH(DEPTH)) u_head (
    .clk_i, .rst_ni, .adv_i(commit), .clr_i(flush), .ptr_o(head_q)
  );

  rob_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_ent (
    .clk_i, .rst_ni,
    .clr_i        (flush),
    .alloc_i      (iss_go),
    .alloc_idx_i  (tail_q[TAG_W-1:0]),
    .alloc_kind_i (kind_e'(iss_kind_i)),
    .alloc_dest_i (iss_dest_i),
    .free_i       (commit),
    .free_idx_i   (head_q[TAG_W-1:0]),
    .wr_i         (res_valid_i && !flush),
    .wr_idx_i     (res_tag_i),
    .wr_value_i   (res_value_i),
    .wr_mis_i     (res_mispred_i),
    .wr_tgt_i     (res_target_i),
    .head_idx_i   (head_q[TAG_W-1:0]),
    .head_kind_o  (h_kind),
    .head_dest_o  (h_dest),
    .head_value_o (h_value),
    .head_ready_o (h_ready),
    .head_mis_o   (h_mis),
    .head_tgt_o   (h_tgt),
    .lk_idx_i     (lk_tag_i),
    .lk_hit_o     (lk_hit_o),
    .lk_value_o   (lk_value_o)
  );

  rob_retire #(.DATA_W(DATA_W), .DEST_W(DEST_W), .REG_W(REG_W)) u_ret (
    .empty_i       (empty),
    .ready_i       (h_ready),
    .kind_i        (h_kind),
    .dest_i        (h_dest),
    .value_i       (h_value),
    .mis_i         (h_mis),
    .tgt_i         (h_tgt),
    .commit_o      (commit),
    .flush_o       (flush),
    .reg_we_o      (reg_we_o),
    .reg_idx_o     (reg_idx_o),
    .reg_data_o    (reg_data_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_data_o    (mem_data_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );
endmodule

// File: rtl/spec_rob_chk.sv
module spec_rob_chk #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iss_valid_i,
  input logic             iss_stall_o,
  input logic [TAG_W-1:0] iss_tag_o,
  input logic             lk_hit_o,
  input logic             reg_we_o,
  input logic             mem_we_o,
  input logic             redirect_o,
  input logic             commit_i
);
  logic [TAG_W:0]   occ_q;
  logic [TAG_W-1:0] exp_tail_q;
  logic             acc;

  assign acc = iss_valid_i && !iss_stall_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q      <= '0;
      exp_tail_q <= '0;
    end else if (redirect_o) begin
      occ_q      <= '0;
      exp_tail_q <= '0;
    end else begin
      occ_q <= occ_q + (TAG_W+1)'(acc) - (TAG_W+1)'(commit_i);
      if (acc) exp_tail_q <= (exp_tail_q == TAG_W'(DEPTH - 1)) ? '0 : exp_tail_q + 1'b1;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= (TAG_W+1)'(DEPTH));

  // R2
  tag_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> iss_tag_o == exp_tail_q);

  // R4
  commit_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> occ_q != '0);

  // R5 R6 R8
  single_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, mem_we_o, redirect_o}));

  // R8
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !lk_hit_o);

  // R9
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == (TAG_W+1)'(DEPTH) && !commit_i) |-> iss_stall_o);

  // R10
  flush_blocks_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> iss_stall_o);
endmodule

bind spec_rob spec_rob_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .iss_valid_i, .iss_stall_o, .iss_tag_o, .lk_hit_o,
  .reg_we_o, .mem_we_o, .redirect_o, .commit_i(commit)
);

// File: tb/tb_spec_rob.sv
module tb_spec_rob;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int TW = $clog2(DEPTH);

  typedef struct {
    logic [1:0]  k;
    logic [31:0] a;
    logic [31:0] d;
  } ev_t;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0; logic [1:0] iss_kind = 0; logic [31:0] iss_dest = 0;
  logic iss_stall; logic [TW-1:0] iss_tag;
  logic res_valid = 0; logic [TW-1:0] res_tag = 0; logic [31:0] res_value = 0;
  logic res_mis = 0; logic [31:0] res_tgt = 0;
  logic [TW-1:0] lk_tag = 0; logic lk_hit; logic [31:0] lk_value;
  logic reg_we; logic [4:0] reg_idx; logic [31:0] reg_data;
  logic mem_we; logic [31:0] mem_addr, mem_data;
  logic redirect; logic [31:0] redirect_pc;

  int checks = 0, fails = 0;
  ev_t sb[$];
  logic [31:0] pv [DEPTH];
  logic        pm [DEPTH];
  logic [31:0] pt [DEPTH];
  logic [TW-1:0] exp_tail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_rob dut (
    .clk_i(clk), .rst_ni(rst_n),
    .iss_valid_i(iss_valid), .iss_kind_i(iss_kind), .iss_dest_i(iss_dest),
    .iss_stall_o(iss_stall), .iss_tag_o(iss_tag),
    .res_valid_i(res_valid), .res_tag_i(res_tag), .res_value_i(res_value),
    .res_mispred_i(res_mis), .res_target_i(res_tgt),
    .lk_tag_i(lk_tag), .lk_hit_o(lk_hit), .lk_value_o(lk_value),
    .reg_we_o(reg_we), .reg_idx_o(reg_idx), .reg_data_o(reg_data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compare every visible retirement against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && (reg_we || mem_we || redirect)) begin
      ev_t got, e;
      got.k = redirect ? 2'd0 : (mem_we ? 2'd1 : 2'd2);
      got.a = redirect ? 32'd0 : (mem_we ? mem_addr : {27'd0, reg_idx});
      got.d = redirect ? redirect_pc : (mem_we ? mem_data : reg_data);
      if (sb.size() == 0) begin
        chk(0, "R4 unexpected retire", {30'd0, got.k}, 32'hffff_ffff);
      end else begin
        e = sb.pop_front();
        chk(got.k == e.k, "R4 retire kind", {30'd0, got.k}, {30'd0, e.k});
        chk(got.a == e.a, "R5/R6 retire dest", got.a, e.a);
        chk(got.d == e.d, "R5/R6/R8 retire data", got.d, e.d);
      end
    end
  end

  // Tasks start and end just after a rising edge.
  task automatic issue(input logic [1:0] k, input logic [31:0] dst, input logic [31:0] val,
                       input logic mis, input logic [31:0] tgt, input bit visible,
                       output logic [TW-1:0] tag);
    ev_t e;
    iss_valid = 1; iss_kind = k; iss_dest = dst;
    @(negedge clk);
    chk(iss_stall == 0, "R2 stall on issue", {31'd0, iss_stall}, 0);
    chk(iss_tag == exp_tail, "R2 issue tag", {29'd0, iss_tag}, {29'd0, exp_tail});
    tag = iss_tag;
    pv[tag] = val; pm[tag] = mis; pt[tag] = tgt;
    if (visible) begin
      e.k = (k == 2'd0) ? 2'd0 : k;
      e.a = (k == 2'd2) ? {27'd0, dst[4:0]} : ((k == 2'd1) ? dst : 32'd0);
      e.d = (k == 2'd0) ? tgt : val;
      sb.push_back(e);
    end
    @(posedge clk); #1;
    iss_valid = 0;
    exp_tail = (exp_tail == TW'(DEPTH - 1)) ? '0 : exp_tail + 1'b1;
  endtask

  task automatic complete(input logic [TW-1:0] t);
    res_valid = 1; res_tag = t; res_value = pv[t]; res_mis = pm[t]; res_tgt = pt[t];
    @(posedge clk); #1;
    res_valid = 0;
  endtask

  task automatic lookup(input logic [TW-1:0] t, input logic hit, input logic [31:0] val, input string req);
    lk_tag = t;
    @(negedge clk);
    chk(lk_hit == hit, req, {31'd0, lk_hit}, {31'd0, hit});
    if (hit) chk(lk_value == val, req, lk_value, val);
    @(posedge clk); #1;
  endtask

  task automatic drain();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sb.size() == 0) break;
    end
    @(posedge clk); #1;
    chk(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [TW-1:0] t0, t1, t2, t3, t4, t5, tb_, tf[DEPTH], t9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(iss_stall == 0, "R1 stall", {31'd0, iss_stall}, 0);
    chk(iss_tag == 0, "R1 tag", {29'd0, iss_tag}, 0);
    chk(!(reg_we || mem_we || redirect), "R1 no retire", {29'd0, reg_we, mem_we, redirect}, 0);
    chk(lk_hit == 0, "R1 lookup", {31'd0, lk_hit}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R2 R3 R4 R5 R6: out-of-order completion, in-order retire
    issue(2'd2, 32'd5,     32'hAAAA_0001, 0, 0, 1, t0);
    issue(2'd1, 32'h100,   32'hBBBB_0002, 0, 0, 1, t1);
    issue(2'd2, 32'h27,    32'hCCCC_0003, 0, 0, 1, t2);
    complete(t2);
    complete(t1);
    lookup(t2, 1, 32'hCCCC_0003, "R3 lookup ready value");
    chk(!(reg_we || mem_we), "R4 no retire while head not ready", {30'd0, reg_we, mem_we}, 0);
    lookup(t0, 0, 0, "R3 lookup not-ready miss");
    complete(t0);
    drain();

    // R3 write to unallocated tag ignored; new entry not hit
    complete(TW'(exp_tail + 2));
    issue(2'd2, 32'd1, 32'h1111, 0, 0, 1, t3);
    issue(2'd2, 32'd2, 32'h2222, 0, 0, 1, t4);
    issue(2'd2, 32'd3, 32'h3333, 0, 0, 1, t5);
    lookup(t5, 0, 0, "R3 stale write ignored");
    complete(t3); complete(t4); complete(t5);
    drain();

    // R7 correctly predicted branch retires silently
    issue(2'd2, 32'd9,  32'h0909, 0, 0, 1, t0);
    issue(2'd0, 32'd0,  32'h0,    0, 32'h8888, 0, tb_);
    issue(2'd2, 32'd10, 32'h1010, 0, 0, 1, t1);
    complete(tb_); complete(t1); complete(t0);
    drain();

    // R8 R10 mispredicted branch flushes younger work
    issue(2'd2, 32'd11,   32'h1111_000B, 0, 0, 1, t0);
    issue(2'd0, 32'd0,    32'h0,         1, 32'h0000_4000, 1, tb_);
    issue(2'd2, 32'd12,   32'h1212,      0, 0, 0, t1);
    issue(2'd1, 32'h200,  32'h2020,      0, 0, 0, t2);
    complete(t1); complete(t2); complete(t0); complete(tb_);
    for (int i = 0; i < 10; i++) begin
      if (redirect) break;
      @(negedge clk);
    end
    chk(redirect == 1, "R8 redirect raised", {31'd0, redirect}, 1);
    iss_valid = 1; iss_kind = 2'd2; iss_dest = 32'd3;
    res_valid = 1; res_tag = t1; res_value = 32'hDEAD; res_mis = 0;
    #1;
    chk(iss_stall == 1, "R10 stall during flush", {31'd0, iss_stall}, 1);
    @(posedge clk); #1;
    iss_valid = 0; res_valid = 0;
    exp_tail = 0;
    lk_tag = t1;
    @(negedge clk);
    chk(iss_tag == 0, "R8 tag restarts", {29'd0, iss_tag}, 0);
    chk(lk_hit == 0, "R8/R10 flushed entry misses", {31'd0, lk_hit}, 0);
    chk(iss_stall == 0, "R8 empty after flush", {31'd0, iss_stall}, 0);
    chk(sb.size() == 0, "R8 younger work squashed", sb.size(), 0);
    @(posedge clk); #1;

    // R9 full stall and issue alongside commit
    for (int i = 0; i < DEPTH; i++)
      issue(2'd2, 32'(i + 16), 32'h5000 + 32'(i), 0, 0, 1, tf[i]);
    iss_valid = 1; iss_kind = 2'd1; iss_dest = 32'h300;
    @(negedge clk);
    chk(iss_stall == 1, "R9 stall when full", {31'd0, iss_stall}, 1);
    @(posedge clk); #1;
    res_valid = 1; res_tag = tf[0]; res_value = pv[tf[0]]; res_mis = 0;
    @(posedge clk); #1;
    res_valid = 0;
    @(negedge clk);
    chk(iss_stall == 0, "R9 issue with commit while full", {31'd0, iss_stall}, 0);
    chk(iss_tag == tf[0], "R9 reuse freed slot", {29'd0, iss_tag}, {29'd0, tf[0]});
    t9 = iss_tag;
    pv[t9] = 32'h9999; pm[t9] = 0;
    sb.push_back('{k: 2'd1, a: 32'h300, d: 32'h9999});
    @(posedge clk); #1;
    iss_valid = 0;
    for (int i = 1; i < DEPTH; i++) complete(tf[i]);
    complete(t9);
    drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule